// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block takes over the byte-wide memory bus of an 8-bit-data processor with a wide address space whenever control must move through an exception path. It serves four kinds of transfer: a reset entry, a hardware interrupt entry, a software break entry, and the return from an interrupt handler. Entries save the return address and the flags on a descending stack in page one, then read a four-byte little-endian vector. Returns pull the flags and the return address back. Instruction decode and arithmetic stay in the surrounding core.

The core presents its current program counter, flags and stack pointer together with a one-cycle request. The sequencer then drives address, write enable and write data one byte per clock. It raises `busy_o` while it owns the bus. In its last cycle it places the new program counter on the address bus as the first fetch, and pulses `done_o` to hand the new program counter, flags and stack pointer back to the core. A wait-for-interrupt request parks the block with `rdy_o` low until an interrupt line wakes it. While `bus_ready` is low, everything is frozen.

Top module: `exc_sequencer`

## Requirements
- R1: After synchronous reset, `busy_o`, `we_o` and `done_o` are 0 and `rdy_o` is 1.
- R2: An interrupt or break entry writes the 4-byte return address most significant byte first, one byte per clock, at stack address 0x100+SP, with SP decremented after each write.
- R3: The fifth entry write puts the flags byte at the next lower stack address. Bit 4 (break) of that byte is 1 for a break and 0 for an interrupt; the other bits are the flags as given.
- R4: A break saves its opcode address plus 2 as the return address; an interrupt saves the current program counter unchanged.
- R5: The vector is read one byte per clock in ascending address order and assembled little-endian. A reset reads 0xFFFFFFF8..0xFFFFFFFB and makes no stack writes. Interrupts and breaks read 0xFFFFFFFC..0xFFFFFFFF.
- R6: The final cycle of every sequence drives the new program counter as a read address and pulses `done_o` for one clock. On an entry, `status_o` is the saved flags with bit 2 (interrupt disable) set and bit 4 cleared, and `sp_o` is the starting SP minus the number of writes.
- R7: A return reads 0x100+SP once and discards the byte. It then reads the flags at SP+1 and the program counter at SP+2..SP+5, least significant byte first. It commits SP+5 and the pulled flags with bit 4 cleared.
- R8: An interrupt request while flag bit 2 is set is ignored: there is no bus activity and `busy_o` stays 0.
- R9: A wait request drives `rdy_o` low with no bus activity. An interrupt wakes the block; with bit 2 clear it starts an interrupt entry, and with bit 2 set it only returns to the running state.
- R10: Stack pointer arithmetic wraps within 8 bits, so every stack access stays in 0x100..0x1FF.
- R11: While `bus_ready` is low, the sequencer state, the bus outputs and the returned values hold, and `done_o` stays 0.
- R12: Simultaneous requests in the idle state are served in the order reset, break, return, interrupt, wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_ready | input | 1 | Bus can advance this cycle; low freezes the block |
| req_reset | input | 1 | Start a reset entry |
| req_irq | input | 1 | Hardware interrupt request line |
| req_brk | input | 1 | Start a break entry (opcode address on cur_pc) |
| req_rti | input | 1 | Start a return from interrupt |
| req_wait | input | 1 | Enter the wait-for-interrupt state |
| cur_pc | input | ADDR_W | Core program counter at request time |
| cur_status | input | 8 | Core flags at request time |
| cur_sp | input | 8 | Core stack pointer at request time |
| din | input | 8 | Read data for the current address |
| addr_o | output | ADDR_W | Bus address |
| dout_o | output | 8 | Write data |
| we_o | output | 1 | Write enable |
| rdy_o | output | 1 | Low while waiting for an interrupt |
| busy_o | output | 1 | Sequencer owns the bus |
| done_o | output | 1 | One-clock strobe that commits pc_o, status_o, sp_o |
| pc_o | output | ADDR_W | New program counter |
| status_o | output | 8 | New flags |
| sp_o | output | 8 | New stack pointer |

## Verification
The bench builds the block with its defaults: 32-bit addresses, a break length of 2, stack page 0x01, and vectors in the top eight bytes of the address space. Its memory model decodes exactly those windows. With these values, a break followed by a return can be checked byte for byte through the same stack bytes. A start pointer of 0x01 makes the push cross from 0x100 to 0x1FF, and full 32-bit vectors show that the assembly is little-endian.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

    localparam int IDX_W     = 4;
    localparam int FLAG_IDIS = 2;
    localparam int FLAG_BRK  = 4;
    localparam logic [7:0] IDIS_MASK = 8'(1 << FLAG_IDIS);
    localparam logic [7:0] BRK_MASK  = 8'(1 << FLAG_BRK);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_PUSH,
        ST_VEC,
        ST_RSP,
        ST_PULL,
        ST_FETCH
    } seq_state_e;

    typedef enum logic [1:0] {
        KIND_RESET,
        KIND_IRQ,
        KIND_BRK,
        KIND_RET
    } seq_kind_e;

    typedef struct packed {
        seq_state_e       state;
        seq_kind_e        kind;
        logic [IDX_W-1:0] idx;
    } seq_ctl_t;

    // flags as they are written to the stack
    function automatic logic [7:0] pushed_flags(input logic [7:0] s, input logic is_brk);
        return is_brk ? (s | BRK_MASK) : (s & ~BRK_MASK);
    endfunction

    // flags handed back to the core after an entry
    function automatic logic [7:0] entry_flags(input logic [7:0] s);
        return (s | IDIS_MASK) & ~BRK_MASK;
    endfunction

endpackage

// File: rtl/exc_seq_ctrl.sv
module exc_seq_ctrl
    import exc_seq_pkg::*;
#(
    parameter int PC_BYTES = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     go,
    input  logic     req_reset,
    input  logic     req_irq,
    input  logic     req_brk,
    input  logic     req_rti,
    input  logic     req_wait,
    input  logic     idis,
    output seq_ctl_t ctl
);

    localparam logic [IDX_W-1:0] LAST_VEC  = IDX_W'(PC_BYTES - 1);
    localparam logic [IDX_W-1:0] LAST_XFER = IDX_W'(PC_BYTES);

    seq_ctl_t nxt;

    always_comb begin
        nxt = ctl;
        unique case (ctl.state)
            ST_IDLE: begin
                nxt.idx = '0;
                if (req_reset) begin
                    nxt.state = ST_VEC;
                    nxt.kind  = KIND_RESET;
                end else if (req_brk) begin
                    nxt.state = ST_PUSH;
                    nxt.kind  = KIND_BRK;
                end else if (req_rti) begin
                    nxt.state = ST_RSP;
                    nxt.kind  = KIND_RET;
                end else if (req_irq && !idis) begin
                    nxt.state = ST_PUSH;
                    nxt.kind  = KIND_IRQ;
                end else if (req_wait) begin
                    nxt.state = ST_WAIT;
                end
            end
            ST_WAIT: begin
                nxt.idx = '0;
                if (req_reset) begin
                    nxt.state = ST_VEC;
                    nxt.kind  = KIND_RESET;
                end else if (req_irq) begin
                    nxt.state = idis ? ST_IDLE : ST_PUSH;
                    nxt.kind  = KIND_IRQ;
                end
            end
            ST_PUSH: begin
                if (ctl.idx == LAST_XFER) begin
                    nxt.state = ST_VEC;
                    nxt.idx   = '0;
                end else begin
                    nxt.idx = ctl.idx + 1'b1;
                end
            end
            ST_VEC: begin
                if (ctl.idx == LAST_VEC) begin
                    nxt.state = ST_FETCH;
                end else begin
                    nxt.idx = ctl.idx + 1'b1;
                end
            end
            ST_RSP: begin
                nxt.state = ST_PULL;
                nxt.idx   = '0;
            end
            ST_PULL: begin
                if (ctl.idx == LAST_XFER) begin
                    nxt.state = ST_FETCH;
                end else begin
                    nxt.idx = ctl.idx + 1'b1;
                end
            end
            ST_FETCH: nxt.state = ST_IDLE;
            default:  nxt.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '{state: ST_IDLE, kind: KIND_RESET, idx: '0};
        end else if (go) begin
            ctl <= nxt;
        end
    end

    // the transfer counter never runs past the last byte of a phase
    assert_idx_bound_R2: assert property (@(posedge clk) disable iff (rst)
        ctl.idx <= LAST_XFER);

endmodule

// File: rtl/exc_seq_regs.sv
module exc_seq_regs
    import exc_seq_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int PC_BYTES = 4,
    parameter int BRK_LEN  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  seq_ctl_t          ctl,
    input  logic              req_brk,
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic [7:0]        cur_status,
    input  logic [7:0]        cur_sp,
    input  logic [7:0]        din,
    output logic [ADDR_W-1:0] ret_pc,
    output logic [ADDR_W-1:0] new_pc,
    output logic [7:0]        flags,
    output logic [7:0]        sp
);

    localparam logic [IDX_W-1:0] LAST_XFER = IDX_W'(PC_BYTES);

    logic [PC_BYTES-1:0] byte_ld;

    // one load strobe per program counter byte: vector read or pull
    for (genvar b = 0; b < PC_BYTES; b++) begin : g_ld
        assign byte_ld[b] = go &&
            ((ctl.state == ST_VEC  && ctl.idx == IDX_W'(b)) ||
             (ctl.state == ST_PULL && ctl.idx == IDX_W'(b + 1)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            new_pc <= '0;
        end else begin
            for (int b = 0; b < PC_BYTES; b++) begin
                if (byte_ld[b]) new_pc[8*b +: 8] <= din;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ret_pc <= '0;
            flags  <= '0;
            sp     <= '0;
        end else if (go) begin
            unique case (ctl.state)
                ST_IDLE, ST_WAIT: begin
                    ret_pc <= cur_pc +
                        ((ctl.state == ST_IDLE && req_brk) ? ADDR_W'(BRK_LEN) : '0);
                    flags  <= cur_status;
                    sp     <= cur_sp;
                end
                ST_PUSH: sp <= sp - 8'd1;
                ST_RSP:  sp <= sp + 8'd1;
                ST_PULL: begin
                    if (ctl.idx == '0) flags <= din;
                    if (ctl.idx != LAST_XFER) sp <= sp + 8'd1;
                end
                default: ;
            endcase
        end
    end

    // a pulled flags byte is only taken in the first pull cycle
    assert_pull_flags_R7: assert property (@(posedge clk) disable iff (rst)
        (go && ctl.state == ST_PULL && ctl.idx != '0) |=> $stable(flags));

endmodule

// File: rtl/exc_seq_bus.sv
module exc_seq_bus
    import exc_seq_pkg::*;
#(
    parameter int               ADDR_W     = 32,
    parameter int               PC_BYTES   = 4,
    parameter logic [7:0]       STACK_PAGE = 8'h01,
    parameter logic [ADDR_W-1:0] VEC_RESET = '0,
    parameter logic [ADDR_W-1:0] VEC_IRQ   = '0
) (
    input  seq_ctl_t          ctl,
    input  logic [ADDR_W-1:0] ret_pc,
    input  logic [ADDR_W-1:0] new_pc,
    input  logic [7:0]        flags,
    input  logic [7:0]        sp,
    output logic [ADDR_W-1:0] addr_o,
    output logic [7:0]        dout_o,
    output logic              we_o
);

    logic [ADDR_W-1:0] stack_addr;
    logic [ADDR_W-1:0] vec_base;
    logic [7:0]        push_byte;

    assign stack_addr = {{(ADDR_W-16){1'b0}}, STACK_PAGE, sp};
    assign vec_base   = (ctl.kind == KIND_RESET) ? VEC_RESET : VEC_IRQ;

    // return address goes out most significant byte first
    always_comb begin
        push_byte = pushed_flags(flags, ctl.kind == KIND_BRK);
        for (int b = 0; b < PC_BYTES; b++) begin
            if (ctl.idx == IDX_W'(PC_BYTES - 1 - b)) push_byte = ret_pc[8*b +: 8];
        end
    end

    always_comb begin
        addr_o = '0;
        dout_o = '0;
        we_o   = 1'b0;
        unique case (ctl.state)
            ST_PUSH: begin
                addr_o = stack_addr;
                dout_o = push_byte;
                we_o   = 1'b1;
            end
            ST_RSP, ST_PULL: addr_o = stack_addr;
            ST_VEC:          addr_o = vec_base + ADDR_W'(ctl.idx);
            ST_FETCH:        addr_o = new_pc;
            default: ;
        endcase
    end

endmodule

// File: rtl/exc_sequencer.sv
module exc_sequencer
    import exc_seq_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                BRK_LEN    = 2,
    parameter logic [7:0]        STACK_PAGE = 8'h01,
    parameter logic [ADDR_W-1:0] VEC_RESET  = {ADDR_W{1'b1}} - ADDR_W'(7),
    parameter logic [ADDR_W-1:0] VEC_IRQ    = {ADDR_W{1'b1}} - ADDR_W'(3)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_ready,
    input  logic              req_reset,
    input  logic              req_irq,
    input  logic              req_brk,
    input  logic              req_rti,
    input  logic              req_wait,
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic [7:0]        cur_status,
    input  logic [7:0]        cur_sp,
    input  logic [7:0]        din,
    output logic [ADDR_W-1:0] addr_o,
    output logic [7:0]        dout_o,
    output logic              we_o,
    output logic              rdy_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic [7:0]        status_o,
    output logic [7:0]        sp_o
);

    localparam int PC_BYTES = ADDR_W / 8;
    localparam logic [IDX_W-1:0] LAST_VEC = IDX_W'(PC_BYTES - 1);

    seq_ctl_t          ctl;
    logic [ADDR_W-1:0] ret_pc;
    logic [ADDR_W-1:0] new_pc;
    logic [7:0]        flags;
    logic [7:0]        sp;

    exc_seq_ctrl #(.PC_BYTES(PC_BYTES)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .go        (bus_ready),
        .req_reset (req_reset),
        .req_irq   (req_irq),
        .req_brk   (req_brk),
        .req_rti   (req_rti),
        .req_wait  (req_wait),
        .idis      (cur_status[FLAG_IDIS]),
        .ctl       (ctl)
    );

    exc_seq_regs #(.ADDR_W(ADDR_W), .PC_BYTES(PC_BYTES), .BRK_LEN(BRK_LEN)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .go         (bus_ready),
        .ctl        (ctl),
        .req_brk    (req_brk),
        .cur_pc     (cur_pc),
        .cur_status (cur_status),
        .cur_sp     (cur_sp),
        .din        (din),
        .ret_pc     (ret_pc),
        .new_pc     (new_pc),
        .flags      (flags),
        .sp         (sp)
    );

    exc_seq_bus #(
        .ADDR_W     (ADDR_W),
        .PC_BYTES   (PC_BYTES),
        .STACK_PAGE (STACK_PAGE),
        .VEC_RESET  (VEC_RESET),
        .VEC_IRQ    (VEC_IRQ)
    ) u_bus (
        .ctl    (ctl),
        .ret_pc (ret_pc),
        .new_pc (new_pc),
        .flags  (flags),
        .sp     (sp),
        .addr_o (addr_o),
        .dout_o (dout_o),
        .we_o   (we_o)
    );

    assign rdy_o    = (ctl.state != ST_WAIT);
    assign busy_o   = (ctl.state != ST_IDLE) && (ctl.state != ST_WAIT);
    assign done_o   = (ctl.state == ST_FETCH) && bus_ready;
    assign pc_o     = new_pc;
    assign sp_o     = sp;
    assign status_o = (ctl.kind == KIND_RET) ? (flags & ~BRK_MASK) : entry_flags(flags);

    assert_push_desc_R10: assert property (@(posedge clk) disable iff (rst)
        (we_o && bus_ready) |=> (!we_o || addr_o[7:0] == $past(addr_o[7:0]) - 8'd1));

    assert_stack_page_R2: assert property (@(posedge clk) disable iff (rst)
        we_o |-> addr_o[ADDR_W-1:8] == {{(ADDR_W-16){1'b0}}, STACK_PAGE});

    assert_hold_bus_R11: assert property (@(posedge clk) disable iff (rst)
        (!bus_ready) |=> ($stable(addr_o) && $stable(we_o) && $stable(dout_o) && $stable(pc_o)));

    assert_no_done_held_R11: assert property (@(posedge clk) disable iff (rst)
        !bus_ready |-> !done_o);

    assert_wait_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !rdy_o |-> (!we_o && !busy_o));

    assert_vec_ascend_R5: assert property (@(posedge clk) disable iff (rst)
        (ctl.state == ST_VEC && bus_ready && ctl.idx != LAST_VEC) |=> addr_o == $past(addr_o) + ADDR_W'(1));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

endmodule

// File: tb/tb_exc_sequencer.sv
module tb_exc_sequencer;

    localparam logic [31:0] RST_TARGET = 32'h1234_5678;
    localparam logic [31:0] IRQ_TARGET = 32'hBEEF_B055;

    typedef struct {
        logic [31:0] a;
        logic        w;
        logic [7:0]  d;
        logic        fin;
        logic [31:0] pc;
        logic [7:0]  st;
        logic [7:0]  sp;
        string       rq;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_ready = 1'b1;
    logic        req_reset = 1'b0, req_irq = 1'b0, req_brk = 1'b0, req_rti = 1'b0, req_wait = 1'b0;
    logic [31:0] cur_pc = '0;
    logic [7:0]  cur_status = '0;
    logic [7:0]  cur_sp = '0;
    logic [7:0]  din;
    logic [31:0] addr_o, pc_o;
    logic [7:0]  dout_o, status_o, sp_o;
    logic        we_o, rdy_o, busy_o, done_o;

    logic [7:0]  stk [256];
    item_t       q[$];
    int          nchk = 0;
    int          nerr = 0;
    int          cyc = 0;

    always #4 clk = ~clk;

    exc_sequencer dut (
        .clk(clk), .rst(rst), .bus_ready(bus_ready),
        .req_reset(req_reset), .req_irq(req_irq), .req_brk(req_brk),
        .req_rti(req_rti), .req_wait(req_wait),
        .cur_pc(cur_pc), .cur_status(cur_status), .cur_sp(cur_sp), .din(din),
        .addr_o(addr_o), .dout_o(dout_o), .we_o(we_o), .rdy_o(rdy_o),
        .busy_o(busy_o), .done_o(done_o), .pc_o(pc_o), .status_o(status_o), .sp_o(sp_o)
    );

    // memory model: stack page and the two vectors, asynchronous read
    always_comb begin
        din = 8'h00;
        if (addr_o[31:8] == 24'h000001) din = stk[addr_o[7:0]];
        else if (addr_o >= 32'hFFFF_FFF8)
            din = addr_o[2] ? IRQ_TARGET[8*addr_o[1:0] +: 8] : RST_TARGET[8*addr_o[1:0] +: 8];
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst && we_o && bus_ready) stk[addr_o[7:0]] <= dout_o;
    end

    task automatic chk(input bit ok, input string rq, input string msg);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: %s", rq, msg);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && busy_o) begin
            if (q.size() == 0) begin
                chk(1'b0, "R2", $sformatf("unexpected bus cycle addr=%h we=%b expected idle", addr_o, we_o));
            end else if (!bus_ready) begin
                chk(addr_o == q[0].a && we_o == q[0].w && !done_o, "R11",
                    $sformatf("held addr=%h we=%b done=%b expected addr=%h we=%b done=0",
                              addr_o, we_o, done_o, q[0].a, q[0].w));
            end else begin
                item_t it;
                bit ok;
                it = q.pop_front();
                ok = addr_o == it.a && we_o == it.w && (!it.w || dout_o == it.d) && done_o == it.fin;
                if (it.fin) ok = ok && pc_o == it.pc && status_o == it.st && sp_o == it.sp;
                chk(ok, it.rq, $sformatf(
                    "addr=%h we=%b dout=%h done=%b pc=%h st=%h sp=%h expected addr=%h we=%b dout=%h done=%b pc=%h st=%h sp=%h",
                    addr_o, we_o, dout_o, done_o, pc_o, status_o, sp_o,
                    it.a, it.w, it.d, it.fin, it.pc, it.st, it.sp));
            end
        end
    end

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic push_item(input logic [31:0] a, input logic w, input logic [7:0] d, input string rq);
        item_t it;
        it = '{a: a, w: w, d: d, fin: 1'b0, pc: '0, st: '0, sp: '0, rq: rq};
        q.push_back(it);
    endtask

    task automatic push_fin(input logic [31:0] pc, input logic [7:0] st, input logic [7:0] sp, input string rq);
        item_t it;
        it = '{a: pc, w: 1'b0, d: '0, fin: 1'b1, pc: pc, st: st, sp: sp, rq: rq};
        q.push_back(it);
    endtask

    // kind: 0 reset, 1 interrupt, 2 break
    task automatic exp_entry(input int kind, input logic [31:0] pc, input logic [7:0] st, input logic [7:0] sp);
        logic [7:0]  s;
        logic [31:0] ret, base, tgt;
        s = sp;
        if (kind != 0) begin
            ret = (kind == 2) ? pc + 32'd2 : pc;             // R4
            for (int k = 0; k < 4; k++) begin
                push_item(32'h100 | 32'(s), 1'b1, ret[8*(3-k) +: 8], "R2");
                s = s - 8'd1;
            end
            push_item(32'h100 | 32'(s), 1'b1, (kind == 2) ? (st | 8'h10) : (st & 8'hEF), "R3");
            s = s - 8'd1;
            base = 32'hFFFF_FFFC;
            tgt  = IRQ_TARGET;
        end else begin
            base = 32'hFFFF_FFF8;
            tgt  = RST_TARGET;
        end
        for (int k = 0; k < 4; k++) push_item(base + 32'(k), 1'b0, 8'h00, "R5");
        push_fin(tgt, (st | 8'h04) & 8'hEF, s, "R6");
    endtask

    task automatic exp_ret(input logic [7:0] sp, input logic [31:0] pc, input logic [7:0] st);
        push_item(32'h100 | 32'(sp), 1'b0, 8'h00, "R7");
        for (int k = 1; k <= 5; k++) push_item(32'h100 | 32'(8'(sp + 8'(k))), 1'b0, 8'h00, "R7");
        push_fin(pc, st & 8'hEF, 8'(sp + 8'd5), "R7");
    endtask

    task automatic pulse(input logic r, input logic i, input logic b, input logic t, input logic w);
        req_reset = r; req_irq = i; req_brk = b; req_rti = t; req_wait = w;
        tick();
        req_reset = 0; req_irq = 0; req_brk = 0; req_rti = 0; req_wait = 0;
    endtask

    task automatic drain;
        while (q.size() != 0) tick();
        tick();
        tick();
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        while (cyc < 20000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog: run hung, cycles=%0d expected below 20000", cyc);
        finish_run();
    end

    initial begin
        for (int k = 0; k < 256; k++) stk[k] = 8'h00;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        chk(!busy_o && !we_o && !done_o && rdy_o, "R1",
            $sformatf("busy=%b we=%b done=%b rdy=%b expected 0 0 0 1", busy_o, we_o, done_o, rdy_o));

        // R5 reset entry: vector only, no stack writes
        cur_status = 8'h00; cur_sp = 8'h40; cur_pc = 32'h0000_0777;
        exp_entry(0, cur_pc, cur_status, cur_sp);
        pulse(1, 0, 0, 0, 0);
        drain();

        // R3/R4 break entry from 0x203 with flags 0xA4, SP 0xFF
        cur_pc = 32'h0000_0203; cur_status = 8'hA4; cur_sp = 8'hFF;
        exp_entry(2, cur_pc, cur_status, cur_sp);
        pulse(0, 0, 1, 0, 0);
        drain();

        // R7 return from the stack written above
        cur_status = 8'h00; cur_sp = 8'hFA;
        exp_ret(8'hFA, 32'h0000_0205, 8'hB4);
        pulse(0, 0, 0, 1, 0);
        drain();

        // R4 interrupt entry with interrupt disable clear
        cur_pc = 32'h1234_5678; cur_status = 8'h81; cur_sp = 8'h80;
        exp_entry(1, cur_pc, cur_status, cur_sp);
        pulse(0, 1, 0, 0, 0);
        drain();

        // R8 interrupt masked by flag bit 2
        cur_status = 8'h04;
        req_irq = 1'b1;
        for (int k = 0; k < 4; k++) begin
            tick();
            chk(!busy_o && !we_o, "R8", $sformatf("busy=%b we=%b expected 0 0", busy_o, we_o));
        end
        req_irq = 1'b0;
        tick();

        // R10 stack wrap from SP 0x01
        cur_pc = 32'hCAFE_F00D; cur_status = 8'h00; cur_sp = 8'h01;
        exp_entry(1, cur_pc, cur_status, cur_sp);
        pulse(0, 1, 0, 0, 0);
        drain();

        // R11 bus stall in the middle of a break push
        cur_pc = 32'h0102_0300; cur_status = 8'h20; cur_sp = 8'hC0;
        exp_entry(2, cur_pc, cur_status, cur_sp);
        pulse(0, 0, 1, 0, 0);
        tick();
        bus_ready = 1'b0;
        repeat (3) tick();
        bus_ready = 1'b1;
        drain();

        // R9 wait: masked interrupt only wakes
        cur_status = 8'h04;
        pulse(0, 0, 0, 0, 1);
        chk(!rdy_o && !busy_o, "R9", $sformatf("rdy=%b busy=%b expected 0 0", rdy_o, busy_o));
        pulse(0, 1, 0, 0, 0);
        chk(rdy_o && !busy_o, "R9", $sformatf("rdy=%b busy=%b expected 1 0", rdy_o, busy_o));
        tick();
        // R9 wait: unmasked interrupt wakes into an entry
        cur_pc = 32'h0000_0901; cur_status = 8'h00; cur_sp = 8'hFF;
        pulse(0, 0, 0, 0, 1);
        chk(!rdy_o, "R9", $sformatf("rdy=%b expected 0", rdy_o));
        exp_entry(1, cur_pc, cur_status, cur_sp);
        pulse(0, 1, 0, 0, 0);
        drain();
        chk(rdy_o, "R9", $sformatf("rdy=%b expected 1", rdy_o));

        // R12 break wins over return, interrupt and wait
        cur_pc = 32'h0000_4440; cur_status = 8'h00; cur_sp = 8'h90;
        exp_entry(2, cur_pc, cur_status, cur_sp);
        pulse(0, 1, 1, 1, 1);
        drain();
        // R12 reset wins over break
        cur_sp = 8'h33;
        exp_entry(0, cur_pc, cur_status, cur_sp);
        pulse(1, 1, 1, 1, 0);
        drain();

        finish_run();
    end

endmodule